// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

A single-cycle combinational execution unit for the bit-manipulation operations of a RISC-V integer pipeline. It sits next to the main ALU in the execute stage. Each cycle it takes a 5-bit operation code, two source operands and a 2-bit scale for scaled adds. It returns one XLEN-wide result and a flag that marks an operation code the configuration does not support.

The unit covers scaled address adds (plain and word-zero-extended), negated-operand logic, signed and unsigned min/max, sign and zero extension, full-width and 32-bit rotates, per-byte OR-combine, byte reversal and single-bit set/clear/invert/extract. The XLEN parameter selects 32 or 64. The word forms exist only at 64. Decode, register file, counting and carry-less multiply belong to other units.

Top module: `bm_alu`

## Requirements
- R1: Code 0 (scaled add) returns rs2 + (rs1 << sh) for sh of 1, 2 or 3. With sh = 0 the code is treated as unsupported.
- R2: The word-zero-extended forms are available only at XLEN 64, and each takes w = rs1[31:0] zero-extended. Code 1 returns rs2 + (w << sh) for sh of 1 to 3, and sh = 0 is unsupported. Code 2 returns rs2 + w. Code 3 returns w << rs2[5:0].
- R3: Code 4 returns rs1 & ~rs2, code 5 returns rs1 | ~rs2 and code 6 returns ~(rs1 ^ rs2).
- R4: Codes 7 and 8 return the signed minimum and maximum of the operands. Codes 9 and 10 return the unsigned minimum and maximum.
- R5: Codes 11 and 12 sign-extend rs1[7:0] and rs1[15:0]. Codes 13 and 14 zero-extend them.
- R6: Code 15 rotates rs1 left and code 16 rotates it right. The amount is rs2 modulo XLEN (its low 5 or 6 bits), and an amount of 0 returns rs1 unchanged.
- R7: At XLEN 64, code 17 rotates rs1[31:0] left and code 18 rotates it right, each by rs2[4:0]. The 32-bit result is sign-extended to 64 bits.
- R8: Code 19 sets each result byte to 8'hFF when the matching rs1 byte is nonzero, and to 8'h00 otherwise.
- R9: Code 20 reverses the byte order of rs1, so that rs1 byte 0 becomes result byte XLEN/8-1.
- R10: Codes 21, 22 and 23 set, clear and invert bit (rs2 mod XLEN) of rs1. Code 24 returns that bit in result bit 0, with all other bits zero.
- R11: Codes 25 to 31 are unsupported, and so are codes 1, 2, 3, 17 and 18 at XLEN 32. An unsupported code gives a result of 0 with illegal_o = 1. Every supported code gives illegal_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| rs1_i | input | XLEN | First source operand |
| rs2_i | input | XLEN | Second source operand, or the amount or bit index |
| sh_i | input | 2 | Left scale for scaled adds |
| res_o | output | XLEN | Result |
| illegal_o | output | 1 | Operation code unsupported in this configuration |

## Verification
The assertions are immediate checks on a purely combinational path. They assume that op_i, rs1_i, rs2_i and sh_i all carry known values, and they are skipped while any input is unknown. The bench drives every input with a defined value from the first cycle. It updates the inputs just after a rising clock edge and compares at the falling edge, so each check sees settled values. The stimulus sweeps all 32 codes and all four scale values over sign-boundary, all-ones and amount-wrap operands, then adds random codes and operands. Both XLEN configurations run side by side.

// File: rtl/bm_alu_pkg.sv
package bm_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_SHADD   = 5'd0,
    OP_SHADDW  = 5'd1,
    OP_ADDW    = 5'd2,
    OP_SLLW    = 5'd3,
    OP_ANDN    = 5'd4,
    OP_ORN     = 5'd5,
    OP_XNOR    = 5'd6,
    OP_MIN     = 5'd7,
    OP_MAX     = 5'd8,
    OP_MINU    = 5'd9,
    OP_MAXU    = 5'd10,
    OP_SEXTB   = 5'd11,
    OP_SEXTH   = 5'd12,
    OP_ZEXTB   = 5'd13,
    OP_ZEXTH   = 5'd14,
    OP_ROL     = 5'd15,
    OP_ROR     = 5'd16,
    OP_ROLW    = 5'd17,
    OP_RORW    = 5'd18,
    OP_ORCB    = 5'd19,
    OP_REV8    = 5'd20,
    OP_BSET    = 5'd21,
    OP_BCLR    = 5'd22,
    OP_BINV    = 5'd23,
    OP_BEXT    = 5'd24
  } op_e;
endpackage

// File: rtl/bm_addgen.sv
module bm_addgen
  import bm_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  op_e             op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [1:0]      sh_i,
  output logic [XLEN-1:0] res_o,
  output logic            own_o
);
  localparam bit WIDE = (XLEN == 64);

  logic [XLEN-1:0] a_w;
  assign a_w = XLEN'(a_i[31:0]);

  always_comb begin
    res_o = '0;
    own_o = 1'b0;
    unique case (op_i)
      OP_SHADD: if (sh_i != 2'd0) begin
        own_o = 1'b1;
        res_o = b_i + (a_i << sh_i);
      end
      OP_SHADDW: if (WIDE && sh_i != 2'd0) begin
        own_o = 1'b1;
        res_o = b_i + (a_w << sh_i);
      end
      OP_ADDW: if (WIDE) begin
        own_o = 1'b1;
        res_o = b_i + a_w;
      end
      OP_SLLW: if (WIDE) begin
        own_o = 1'b1;
        res_o = a_w << b_i[5:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bm_logic.sv
module bm_logic
  import bm_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  op_e             op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o,
  output logic            own_o
);
  logic lt_s, lt_u;
  assign lt_s = $signed(a_i) < $signed(b_i);
  assign lt_u = a_i < b_i;

  always_comb begin
    res_o = '0;
    own_o = 1'b1;
    unique case (op_i)
      OP_ANDN:  res_o = a_i & ~b_i;
      OP_ORN:   res_o = a_i | ~b_i;
      OP_XNOR:  res_o = ~(a_i ^ b_i);
      OP_MIN:   res_o = lt_s ? a_i : b_i;
      OP_MAX:   res_o = lt_s ? b_i : a_i;
      OP_MINU:  res_o = lt_u ? a_i : b_i;
      OP_MAXU:  res_o = lt_u ? b_i : a_i;
      OP_SEXTB: res_o = {{(XLEN-8){a_i[7]}}, a_i[7:0]};
      OP_SEXTH: res_o = {{(XLEN-16){a_i[15]}}, a_i[15:0]};
      OP_ZEXTB: res_o = XLEN'(a_i[7:0]);
      OP_ZEXTH: res_o = XLEN'(a_i[15:0]);
      default:  own_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bm_bitrot.sv
module bm_bitrot
  import bm_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  op_e             op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o,
  output logic            own_o
);
  localparam int SHW = $clog2(XLEN);
  localparam int NB  = XLEN / 8;

  logic [SHW-1:0]    amt;
  logic [2*XLEN-1:0] rl_x, rr_x;
  logic [XLEN-1:0]   rol_v, ror_v, orc_v, rev_v, bit_v;
  logic [XLEN-1:0]   rolw_v, rorw_v;
  logic              has_w;
  logic              unused_b;

  assign amt      = b_i[SHW-1:0];
  assign unused_b = ^b_i[XLEN-1:SHW];
  assign rl_x     = {a_i, a_i} << amt;
  assign rr_x     = {a_i, a_i} >> amt;
  assign rol_v    = rl_x[2*XLEN-1:XLEN];
  assign ror_v    = rr_x[XLEN-1:0];
  assign bit_v    = XLEN'(1) << amt;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign orc_v[8*i +: 8]        = {8{|a_i[8*i +: 8]}};
    assign rev_v[8*(NB-1-i) +: 8] = a_i[8*i +: 8];
  end

  if (XLEN == 64) begin : g_word
    logic [63:0] wl_x, wr_x;
    logic [31:0] wl, wr;
    assign wl_x   = {a_i[31:0], a_i[31:0]} << b_i[4:0];
    assign wr_x   = {a_i[31:0], a_i[31:0]} >> b_i[4:0];
    assign wl     = wl_x[63:32];
    assign wr     = wr_x[31:0];
    assign rolw_v = {{32{wl[31]}}, wl};
    assign rorw_v = {{32{wr[31]}}, wr};
    assign has_w  = 1'b1;
  end else begin : g_noword
    assign rolw_v = '0;
    assign rorw_v = '0;
    assign has_w  = 1'b0;
  end

  always_comb begin
    res_o = '0;
    own_o = 1'b1;
    unique case (op_i)
      OP_ROL:  res_o = rol_v;
      OP_ROR:  res_o = ror_v;
      OP_ROLW: begin own_o = has_w; res_o = rolw_v; end
      OP_RORW: begin own_o = has_w; res_o = rorw_v; end
      OP_ORCB: res_o = orc_v;
      OP_REV8: res_o = rev_v;
      OP_BSET: res_o = a_i | bit_v;
      OP_BCLR: res_o = a_i & ~bit_v;
      OP_BINV: res_o = a_i ^ bit_v;
      OP_BEXT: res_o = XLEN'(|(a_i & bit_v));
      default: own_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bm_alu.sv
module bm_alu
  import bm_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic [1:0]      sh_i,
  output logic [XLEN-1:0] res_o,
  output logic            illegal_o
);
  localparam int NU = 3;

  op_e             op;
  logic [XLEN-1:0] u_res [NU];
  logic [NU-1:0]   u_own;

  assign op = op_e'(op_i);

  bm_addgen #(.XLEN(XLEN)) u_add (
    .op_i(op), .a_i(rs1_i), .b_i(rs2_i), .sh_i(sh_i),
    .res_o(u_res[0]), .own_o(u_own[0])
  );
  bm_logic #(.XLEN(XLEN)) u_log (
    .op_i(op), .a_i(rs1_i), .b_i(rs2_i),
    .res_o(u_res[1]), .own_o(u_own[1])
  );
  bm_bitrot #(.XLEN(XLEN)) u_rot (
    .op_i(op), .a_i(rs1_i), .b_i(rs2_i),
    .res_o(u_res[2]), .own_o(u_own[2])
  );

  // Units drive zero when not selected, so results OR together.
  always_comb begin
    res_o = '0;
    for (int i = 0; i < NU; i++) begin
      if (u_own[i]) res_o = res_o | u_res[i];
    end
  end
  assign illegal_o = ~|u_own;
endmodule

// File: rtl/bm_alu_chk.sv
module bm_alu_chk
  import bm_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic [OP_W-1:0] op_i,
  input logic [XLEN-1:0] rs1_i,
  input logic [XLEN-1:0] rs2_i,
  input logic [1:0]      sh_i,
  input logic [XLEN-1:0] res_o,
  input logic            illegal_o
);
  logic known, byte_ok, w_form, supported;

  always_comb begin
    known   = !$isunknown({op_i, rs1_i, rs2_i, sh_i});
    byte_ok = 1'b1;
    for (int i = 0; i < XLEN/8; i++) begin
      if (res_o[8*i +: 8] != 8'h00 && res_o[8*i +: 8] != 8'hFF) byte_ok = 1'b0;
    end
    w_form = op_i inside {5'd1, 5'd2, 5'd3, 5'd17, 5'd18};
    supported = (op_i <= 5'd24) && !(XLEN == 32 && w_form) &&
                !(op_i inside {5'd0, 5'd1} && sh_i == 2'd0);
    if (known) begin
      AST_ILLEGAL_ZERO: assert (!illegal_o || res_o == '0); // R11
      AST_SUPPORTED_LEGAL: assert (supported == !illegal_o); // R11
      AST_ORCB_FULL_BYTES: assert (op_i != 5'd19 || byte_ok); // R8
      AST_BEXT_ONE_BIT: assert (op_i != 5'd24 || res_o[XLEN-1:1] == '0); // R10
      AST_WROT_SIGNEXT: assert (XLEN != 64 || !(op_i inside {5'd17, 5'd18}) ||
                                res_o[XLEN-1:31] == '0 || &res_o[XLEN-1:31]); // R7
      AST_ZEXTB_RANGE: assert (op_i != 5'd13 || res_o[XLEN-1:8] == '0); // R5
    end
  end
endmodule

bind bm_alu bm_alu_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/bm_alu_tb_top.sv
module bm_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [4:0]  op;
  logic [63:0] a, b;
  logic [1:0]  sh;
  logic [63:0] r64;
  logic [31:0] r32;
  logic        ill64, ill32;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bm_alu #(.XLEN(64)) dut_i (
    .op_i(op), .rs1_i(a), .rs2_i(b), .sh_i(sh), .res_o(r64), .illegal_o(ill64)
  );
  bm_alu #(.XLEN(32)) dut32_i (
    .op_i(op), .rs1_i(a[31:0]), .rs2_i(b[31:0]), .sh_i(sh), .res_o(r32), .illegal_o(ill32)
  );

  function automatic string req_of(int o);
    case (o)
      0: return "R1";
      1, 2, 3: return "R2";
      4, 5, 6: return "R3";
      7, 8, 9, 10: return "R4";
      11, 12, 13, 14: return "R5";
      15, 16: return "R6";
      17, 18: return "R7";
      19: return "R8";
      20: return "R9";
      21, 22, 23, 24: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Behavioural model: returns {illegal, result}.
  function automatic logic [64:0] model(int xl, int o, logic [63:0] x, logic [63:0] y, logic [1:0] k);
    logic [63:0] m, r, t;
    logic [31:0] w;
    longint sx, sy;
    int amt, nb;
    bit ill;
    m   = (xl == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF;
    x   = x & m;
    y   = y & m;
    amt = int'(y % 64'(xl));
    nb  = xl / 8;
    sx  = (xl == 64) ? longint'(x) : longint'({{32{x[31]}}, x[31:0]});
    sy  = (xl == 64) ? longint'(y) : longint'({{32{y[31]}}, y[31:0]});
    r   = 0;
    ill = 0;
    case (o)
      0: if (k == 0) ill = 1; else r = y + (x << k);
      1: if (xl == 32 || k == 0) ill = 1; else r = y + ({32'b0, x[31:0]} << k);
      2: if (xl == 32) ill = 1; else r = y + {32'b0, x[31:0]};
      3: if (xl == 32) ill = 1; else r = {32'b0, x[31:0]} << y[5:0];
      4: r = x & ~y;
      5: r = x | ~y;
      6: r = ~(x ^ y);
      7: r = (sx < sy) ? x : y;
      8: r = (sx > sy) ? x : y;
      9: r = (x < y) ? x : y;
      10: r = (x > y) ? x : y;
      11: r = {{56{x[7]}}, x[7:0]};
      12: r = {{48{x[15]}}, x[15:0]};
      13: r = {56'b0, x[7:0]};
      14: r = {48'b0, x[15:0]};
      15, 16: begin
        r = x;
        for (int i = 0; i < amt; i++) begin
          if (o == 15) r = ((r << 1) | (r >> (xl - 1))) & m;
          else         r = ((r >> 1) | (r << (xl - 1))) & m;
        end
      end
      17, 18: if (xl == 32) ill = 1; else begin
        w = x[31:0];
        for (int i = 0; i < int'(y[4:0]); i++) begin
          if (o == 17) w = {w[30:0], w[31]};
          else         w = {w[0], w[31:1]};
        end
        r = {{32{w[31]}}, w};
      end
      19: for (int i = 0; i < nb; i++) r[8*i +: 8] = (x[8*i +: 8] != 0) ? 8'hFF : 8'h00;
      20: for (int i = 0; i < nb; i++) r[8*(nb-1-i) +: 8] = x[8*i +: 8];
      21: begin r = x; r[amt] = 1'b1; end
      22: begin r = x; r[amt] = 1'b0; end
      23: begin r = x; r[amt] = ~x[amt]; end
      24: r = {63'b0, x[amt]};
      default: ill = 1;
    endcase
    if (ill) r = 0;
    t = r & m;
    return {ill, t};
  endfunction

  task automatic apply(int o, logic [63:0] x, logic [63:0] y, logic [1:0] k);
    logic [64:0] e64, e32;
    @(posedge clk);
    #1;
    op = 5'(o); a = x; b = y; sh = k;
    e64 = model(64, o, x, y, k);
    e32 = model(32, o, x, y, k);
    @(negedge clk);
    total++;
    if ({ill64, r64} !== e64) begin
      bad++;
      $display("FAIL %s xlen64 op=%0d a=%h b=%h sh=%0d: got ill=%b res=%h exp ill=%b res=%h",
               req_of(o), o, x, y, k, ill64, r64, e64[64], e64[63:0]);
    end
    total++;
    if ({ill32, r32} !== {e32[64], e32[31:0]}) begin
      bad++;
      $display("FAIL %s xlen32 op=%0d a=%h b=%h sh=%0d: got ill=%b res=%h exp ill=%b res=%h",
               req_of(o), o, x, y, k, ill32, r32, e32[64], e32[31:0]);
    end
  endtask

  logic [63:0] corner_a [6];
  logic [63:0] corner_b [6];

  initial begin
    op = 0; a = 0; b = 0; sh = 0;
    corner_a = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
                 64'h0123_4567_89AB_CDEF, 64'h0000_0000_8000_0001, 64'h00FF_0010_0000_7F80};
    corner_b = '{64'h0, 64'h0000_0000_0000_003F, 64'h7FFF_FFFF_FFFF_FFFF,
                 64'h0000_0000_0000_0021, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_0000_0040};
    // Idle state with all-zero inputs: scale 0 is unsupported (R1, R11).
    apply(0, 64'h0, 64'h0, 2'd0);
    for (int o = 0; o < 32; o++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int k = 0; k < 4; k++)
            apply(o, corner_a[i], corner_b[j], 2'(k));
    for (int n = 0; n < 3000; n++)
      apply(int'($urandom_range(0, 31)), {$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule